// File: doc/BRIEF.md
# Exception Vector Arbiter

This block sits beside a small CPU core and decides, at each instruction boundary, whether an exception is to be taken next and which one. It receives an active-low reset pin, an internal reset request, a software-interrupt strobe from the instruction decoder, four hardware request lines and the current interrupt-mask bit. When an exception is chosen, it emits a one-cycle take pulse. With that pulse it gives the pair of memory addresses, high byte then low byte, that hold the service routine's start address. It also raises a command that sets the mask bit.

Reset has the highest priority. While reset is held the block stays quiet, keeps the reset vector on its address outputs and holds the set-mask command high. Once reset has been released, the block takes the reset vector once. After that, hardware requests are looked at only when the core signals that an instruction is done. An unmasked hardware request is served before a software interrupt offered at the same boundary. A software interrupt ignores the mask. The memory holding the vectors, register stacking and execution belong to the core.

Top module: `excvec_top`

## Requirements
- R1: After every reset is released, the block gives exactly one takeExc pulse with vecAddrHi = 0x1FFE and vecAddrLo = 0x1FFF, and setMask is high in that cycle.
- R2: While rstPinN is low, takeExc is 0, setMask is 1 and the address outputs show 0x1FFE/0x1FFF; the takeExc pulse of R1 comes no more than 8 cycles after release.
- R3: A high rstReqInt acts exactly like a low rstPinN: it holds the block in reset (R2) and is followed by the reset vector (R1).
- R4: On a cycle with instDone = 1 and maskI = 0 and any hwReq bit set, the lowest set bit index wins. Bit 0 (external line) gives 0x1FFA/0x1FFB, bit 1 gives 0x1FF8/0x1FF9, bit 2 gives 0x1FF6/0x1FF7 and bit 3 gives 0x1FF4/0x1FF5.
- R5: With maskI = 1, hwReq has no effect: without swiStrobe, no takeExc follows.
- R6: On instDone = 1 with swiStrobe = 1 and no unmasked hardware request, the SWI vector 0x1FFC/0x1FFD is taken whatever maskI is.
- R7: When an unmasked hardware request and swiStrobe arrive on the same instruction boundary, the hardware vector of R4 is taken and not the SWI vector.
- R8: Requests and swiStrobe on a cycle with instDone = 0 cause no takeExc.
- R9: takeExc is a registered pulse one cycle after the sampling edge, lasting one cycle; setMask is high with every takeExc and low outside reset otherwise.
- R10: vecAddrLo always equals vecAddrHi + 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstPinN | input | 1 | External reset, active low, asynchronous on assertion |
| rstReqInt | input | 1 | Internal reset request, active high |
| instDone | input | 1 | Instruction boundary; requests are sampled here |
| swiStrobe | input | 1 | Software interrupt about to be fetched |
| hwReq | input | 4 | Hardware requests, bit 0 highest priority |
| maskI | input | 1 | Current interrupt-mask bit |
| takeExc | output | 1 | One-cycle pulse: take the exception now |
| vecAddrHi | output | 13 | Address of the vector's high byte |
| vecAddrLo | output | 13 | Address of the vector's low byte |
| setMask | output | 1 | Command to set the interrupt-mask bit |

## Verification
A software interrupt and a hardware request can fall on the same instruction boundary. The bench sweeps every hwReq pattern against both maskI values with swiStrobe low and high, all on a boundary cycle. For each case it works out the expected winner arithmetically: with the mask clear, the lowest set request bit; otherwise SWI, or no take at all. The vector pair is then compared with the one computed for that winner. Each boundary case is followed by the same requests on a cycle that is not a boundary, to show that they are ignored there. Reset arriving from the pin and from the internal request is checked against the reset vector and against a quiet takeExc.

// File: rtl/excvec_pkg.sv
package excvec_pkg;
  localparam int HW_SRC    = 4;
  localparam int VEC_CNT   = HW_SRC + 2;
  localparam int VEC_IDX_W = $clog2(VEC_CNT);

  // vector index: 0 reset, 1 software interrupt, 2.. hardware sources
  localparam logic [VEC_IDX_W-1:0] IDX_RESET = '0;
  localparam logic [VEC_IDX_W-1:0] IDX_SWI   = VEC_IDX_W'(1);

  typedef struct packed {
    logic                 take;
    logic [VEC_IDX_W-1:0] idx;
    logic                 holdMask;
  } ctl_t;
endpackage

// File: rtl/excvec_ctrl.sv
module excvec_ctrl
  import excvec_pkg::*;
(
  input  logic              clk,
  input  logic              rstAll,
  input  logic              instDone,
  input  logic              swiStrobe,
  input  logic [HW_SRC-1:0] hwReq,
  input  logic              maskI,
  output ctl_t              ctl
);
  logic [1:0] rstSync;
  logic inReset;
  logic pendRst;
  logic hwHit;
  logic [VEC_IDX_W-1:0] hwIdx;

  // asynchronous entry, synchronous two-stage release
  always_ff @(posedge clk or posedge rstAll) begin
    if (rstAll) rstSync <= 2'b11;
    else        rstSync <= {rstSync[0], 1'b0};
  end
  assign inReset = rstSync[1];

  always_ff @(posedge clk or posedge rstAll) begin
    if (rstAll)        pendRst <= 1'b1;
    else if (!inReset) pendRst <= 1'b0;
  end

  // fixed priority: lowest index wins
  always_comb begin
    hwIdx = '0;
    for (int i = HW_SRC - 1; i >= 0; i--) begin
      if (hwReq[i]) hwIdx = VEC_IDX_W'(i + 2);
    end
  end
  assign hwHit = (|hwReq) && !maskI;

  always_comb begin
    ctl.holdMask = inReset;
    ctl.take     = 1'b0;
    ctl.idx      = IDX_RESET;
    if (!inReset) begin
      if (pendRst) begin
        ctl.take = 1'b1;
      end else if (instDone && hwHit) begin
        ctl.take = 1'b1;
        ctl.idx  = hwIdx;
      end else if (instDone && swiStrobe) begin
        ctl.take = 1'b1;
        ctl.idx  = IDX_SWI;
      end
    end
  end

  a_r2_quiet_in_reset: assert property (@(posedge clk) inReset |-> !ctl.take);
  a_r5_mask_blocks_hw: assert property (@(posedge clk) disable iff (rstAll)
    (instDone && maskI && !swiStrobe && !pendRst) |-> !ctl.take);
  a_r6_swi_ignores_mask: assert property (@(posedge clk) disable iff (rstAll)
    (!inReset && !pendRst && instDone && swiStrobe && hwReq == '0) |-> (ctl.take && ctl.idx == IDX_SWI));
  a_r8_no_take_off_boundary: assert property (@(posedge clk) disable iff (rstAll)
    (!instDone && !pendRst) |-> !ctl.take);
endmodule

// File: rtl/excvec_dpath.sv
module excvec_dpath
  import excvec_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter logic [ADDR_W-1:0] VEC_TOP = 13'h1FFF
) (
  input  logic              clk,
  input  logic              rstAll,
  input  ctl_t              ctl,
  output logic              takeExc,
  output logic [ADDR_W-1:0] vecAddrHi,
  output logic [ADDR_W-1:0] vecAddrLo,
  output logic              setMask
);
  logic takeQ;
  logic [VEC_IDX_W-1:0] idxQ;
  logic [ADDR_W-1:0] offset;

  always_ff @(posedge clk or posedge rstAll) begin
    if (rstAll) begin
      takeQ <= 1'b0;
      idxQ  <= IDX_RESET;
    end else begin
      takeQ <= ctl.take;
      if (ctl.take) idxQ <= ctl.idx;
    end
  end

  assign offset    = ADDR_W'(idxQ) << 1;
  assign vecAddrLo = VEC_TOP - offset;
  assign vecAddrHi = vecAddrLo - ADDR_W'(1);
  assign takeExc   = takeQ;
  assign setMask   = takeQ | ctl.holdMask;

  a_r10_pair_adjacent: assert property (@(posedge clk) disable iff (rstAll)
    vecAddrLo == vecAddrHi + ADDR_W'(1));
  a_r9_pulse_single: assert property (@(posedge clk) disable iff (rstAll)
    (takeExc && !ctl.take) |=> !takeExc);
endmodule

// File: rtl/excvec_top.sv
module excvec_top
  import excvec_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter logic [ADDR_W-1:0] VEC_TOP = 13'h1FFF
) (
  input  logic              clk,
  input  logic              rstPinN,
  input  logic              rstReqInt,
  input  logic              instDone,
  input  logic              swiStrobe,
  input  logic [HW_SRC-1:0] hwReq,
  input  logic              maskI,
  output logic              takeExc,
  output logic [ADDR_W-1:0] vecAddrHi,
  output logic [ADDR_W-1:0] vecAddrLo,
  output logic              setMask
);
  logic rstAll;
  ctl_t ctl;

  assign rstAll = !rstPinN || rstReqInt;

  excvec_ctrl u_ctrl (
    .clk(clk), .rstAll(rstAll), .instDone(instDone), .swiStrobe(swiStrobe),
    .hwReq(hwReq), .maskI(maskI), .ctl(ctl)
  );

  excvec_dpath #(.ADDR_W(ADDR_W), .VEC_TOP(VEC_TOP)) u_dpath (
    .clk(clk), .rstAll(rstAll), .ctl(ctl), .takeExc(takeExc),
    .vecAddrHi(vecAddrHi), .vecAddrLo(vecAddrLo), .setMask(setMask)
  );
endmodule

// File: tb/excvec_top_test.sv
module excvec_top_test;
  logic clk = 1'b0;
  logic rstPinN = 1'b0;
  logic rstReqInt = 1'b0;
  logic instDone = 1'b0;
  logic swiStrobe = 1'b0;
  logic [3:0] hwReq = '0;
  logic maskI = 1'b0;
  logic takeExc, setMask;
  logic [12:0] vecAddrHi, vecAddrLo;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  excvec_top uut (
    .clk(clk), .rstPinN(rstPinN), .rstReqInt(rstReqInt), .instDone(instDone),
    .swiStrobe(swiStrobe), .hwReq(hwReq), .maskI(maskI), .takeExc(takeExc),
    .vecAddrHi(vecAddrHi), .vecAddrLo(vecAddrLo), .setMask(setMask)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // wait for the reset pulse after release (R1, R2)
  task automatic expectResetPulse(input string req);
    bit seen = 0;
    for (int n = 0; n < 8 && !seen; n++) begin
      @(negedge clk);
      if (takeExc) seen = 1;
    end
    chk({req, " R1 pulse seen"}, 32'(seen), 32'd1);
    chk({req, " R1 hi"}, 32'(vecAddrHi), 32'h1FFE);
    chk({req, " R1 lo"}, 32'(vecAddrLo), 32'h1FFF);
    chk({req, " R1 setMask"}, 32'(setMask), 32'd1);
    @(negedge clk);
    chk({req, " R9 pulse ends"}, 32'(takeExc), 32'd0);
    chk({req, " R9 mask low"}, 32'(setMask), 32'd0);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R2: held in reset, even with a boundary and requests present
    instDone = 1'b1; swiStrobe = 1'b1; hwReq = 4'hF;
    repeat (2) @(negedge clk);
    chk("R2 take held", 32'(takeExc), 32'd0);
    chk("R2 mask held", 32'(setMask), 32'd1);
    chk("R2 hi", 32'(vecAddrHi), 32'h1FFE);
    chk("R2 lo", 32'(vecAddrLo), 32'h1FFF);
    instDone = 1'b0; swiStrobe = 1'b0; hwReq = '0;
    rstPinN = 1'b1;
    expectResetPulse("pin");

    // R4..R8 sweep
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 2; s++) begin
        for (int h = 0; h < 16; h++) begin
          int expTake;
          int expLo;
          expTake = 0; expLo = 0;
          if (m == 0 && h != 0) begin
            int low;
            low = 0;
            for (int b = 3; b >= 0; b--) if (h[b]) low = b;
            expTake = 1; expLo = 'h1FFB - 2 * low;
          end else if (s == 1) begin
            expTake = 1; expLo = 'h1FFD;
          end
          maskI = m[0]; swiStrobe = s[0]; hwReq = h[3:0]; instDone = 1'b1;
          @(negedge clk);
          instDone = 1'b0;
          chk(m ? "R5 R6 take" : "R4 R7 take", 32'(takeExc), 32'(expTake));
          chk("R9 setMask with take", 32'(setMask), 32'(expTake));
          if (expTake == 1) begin
            chk(s && !m && h != 0 ? "R7 lo" : "R4 R6 lo", 32'(vecAddrLo), 32'(expLo));
            chk("R10 hi", 32'(vecAddrHi), 32'(expLo - 1));
          end
          @(negedge clk);
          chk("R8 off boundary", 32'(takeExc), 32'd0);
          chk("R9 mask low", 32'(setMask), 32'd0);
        end
      end
    end
    swiStrobe = 1'b0; hwReq = '0; maskI = 1'b0;

    // R3: internal reset request
    rstReqInt = 1'b1;
    instDone = 1'b1; hwReq = 4'h1;
    @(negedge clk);
    chk("R3 take held", 32'(takeExc), 32'd0);
    chk("R3 mask held", 32'(setMask), 32'd1);
    chk("R3 hi", 32'(vecAddrHi), 32'h1FFE);
    instDone = 1'b0; hwReq = '0;
    @(negedge clk);
    rstReqInt = 1'b0;
    expectResetPulse("R3 internal");

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule